// File: doc/BRIEF.md
# Multiphase Reciprocal Period Counter

This block measures the interval between two successive rising edges of an asynchronous input against a 100 MHz reference clock. A free-running coarse counter in the reference domain gives whole reference cycles. A bank of sixteen sampling flip-flops refines that count. All sixteen receive the input on their D pins, and each is clocked by its own copy of the reference, delayed by k/16 of a period.

The sixteen samples are brought into the reference domain through a two-stage synchroniser. The resulting word, read in phase order, is a thermometer code. The position of its rising transition gives a 4-bit fine phase code. The block joins coarse count and fine code into an edge timestamp, and subtracts the timestamp of the previous edge to give the period. The period is in units of 1/16 reference cycle, which is 625 ps at 100 MHz. It comes out on a one-cycle valid strobe.

The phase clocks are generated and deskewed outside the block, and arrive as a 16-bit clock vector.

Top module: `mpc_period_meter`

## Requirements
- R1: A synchronous active-high reset clears the valid strobe, the period output and the overflow flag to 0 on the next reference edge.
- R2: Bit k of `phase_clk` is the reference delayed by k/16 of a period. The input is sampled on each of these sixteen clocks, and the samples pass through two reference-domain flops before decoding, so that an edge first caught by phase k yields fine code k, for every k from 0 to 15.
- R3: The fine code is the lowest index k for which bit k of the synchronised word is 1 and the bit below it is 0. For k = 0, the bit below is bit 15 of the previous word. A stray 0 above the true transition (a bubble) therefore does not move the code.
- R4: Edge timestamp = coarse_count × 16 + fine_code. The reported period is the current timestamp minus the previous one, in units of 1/16 reference cycle.
- R5: The first rising edge after reset only stores its timestamp and raises no valid strobe.
- R6: Each later rising edge, spaced at least four reference cycles from the previous one, raises `period_valid` for exactly one cycle. `period_out` holds its value between strobes.
- R7: If 2^COARSE_W reference cycles pass after an edge with no new edge, `overflow_flag` is set. It stays set until reset.
- R8: The subtraction is modulo 2^(COARSE_W+4), so a period whose two timestamps straddle a coarse-counter wrap is still exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 100 MHz reference clock; coarse counter and all output logic |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| phase_clk | input | 16 | Sampling clocks; bit k lags the reference by k/16 period |
| sig_in | input | 1 | Asynchronous signal whose period is measured |
| period_out | output | COARSE_W+4 | Last measured period in 1/16 reference-cycle units |
| period_valid | output | 1 | One-cycle strobe marking a new period result |
| overflow_flag | output | 1 | Sticky: a gap between edges exceeded the coarse range |

## Verification
Two things can fall in the same reference cycle: the coarse counter wrapping, and the capture of an edge whose fine code is 0. A code-0 edge is only recognised through bit 15 of the word before, and its timestamp is the one that crosses the wrap. The bench provokes this case with a long train of edges whose fine codes cycle through all sixteen values, using a narrowed coarse counter so that many wraps occur. Each strobed period is judged against a behavioural timestamp difference that the bench computes from the exact instants at which it drives the edges.

// File: rtl/mpc_pkg.sv
`timescale 1ns/1ps
package mpc_pkg;
  localparam int unsigned NUM_PHASES = 16;
  localparam int unsigned FINE_W     = $clog2(NUM_PHASES);
endpackage

// File: rtl/mpc_phase_capture.sv
`timescale 1ns/1ps
// Sixteen phase-clocked samplers followed by a reference-domain synchroniser.
module mpc_phase_capture #(
  parameter int unsigned NPH         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_ref,
  input  logic           rst,
  input  logic [NPH-1:0] phase_clk,
  input  logic           sig_in,
  output logic [NPH-1:0] word
);
  logic [NPH-1:0] raw;
  logic [NPH-1:0] stage [SYNC_STAGES];

  for (genvar k = 0; k < NPH; k++) begin : g_tap
    logic tap_q;
    always_ff @(posedge phase_clk[k]) tap_q <= sig_in;
    assign raw[k] = tap_q;
  end

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign word = stage[SYNC_STAGES-1];
endmodule

// File: rtl/mpc_edge_locator.sv
`timescale 1ns/1ps
// Finds the lowest 0-to-1 transition in the phase-ordered word.
module mpc_edge_locator #(
  parameter int unsigned NPH    = 16,
  parameter int unsigned FINE_W = 4
) (
  input  logic              clk_ref,
  input  logic              rst,
  input  logic [NPH-1:0]    word,
  output logic              edge_hit,
  output logic [FINE_W-1:0] fine_code
);
  logic              prev_msb;
  logic [NPH:0]      ext;
  logic              hit_c;
  logic [FINE_W-1:0] code_c;

  assign ext = {word, prev_msb};

  // Scan from the top down so the lowest transition wins.
  always_comb begin
    hit_c  = 1'b0;
    code_c = '0;
    for (int k = NPH - 1; k >= 0; k--) begin
      if (ext[k+1] && !ext[k]) begin
        hit_c  = 1'b1;
        code_c = FINE_W'(k);
      end
    end
  end

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      prev_msb  <= 1'b0;
      edge_hit  <= 1'b0;
      fine_code <= '0;
    end else begin
      prev_msb  <= word[NPH-1];
      edge_hit  <= hit_c;
      fine_code <= code_c;
    end
  end
endmodule

// File: rtl/mpc_period_calc.sv
`timescale 1ns/1ps
// Coarse counter, timestamp store, modular period and gap overflow.
module mpc_period_calc #(
  parameter int unsigned COARSE_W = 32,
  parameter int unsigned FINE_W   = 4,
  localparam int unsigned TS_W    = COARSE_W + FINE_W
) (
  input  logic              clk_ref,
  input  logic              rst,
  input  logic              edge_hit,
  input  logic [FINE_W-1:0] fine_code,
  output logic [TS_W-1:0]   period_out,
  output logic              period_valid,
  output logic              overflow_flag
);
  localparam logic [COARSE_W:0] GAP_LAST = {1'b0, {COARSE_W{1'b1}}};

  logic [COARSE_W-1:0] coarse;
  logic [TS_W-1:0]     stamp;
  logic [TS_W-1:0]     prev_ts;
  logic                armed;
  logic [COARSE_W:0]   gap_cnt;

  assign stamp = {coarse, fine_code};

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      coarse        <= '0;
      prev_ts       <= '0;
      armed         <= 1'b0;
      gap_cnt       <= '0;
      period_out    <= '0;
      period_valid  <= 1'b0;
      overflow_flag <= 1'b0;
    end else begin
      coarse       <= coarse + 1'b1;
      period_valid <= 1'b0;
      if (edge_hit) begin
        prev_ts <= stamp;
        armed   <= 1'b1;
        gap_cnt <= '0;
        if (armed) begin
          period_out   <= stamp - prev_ts;
          period_valid <= 1'b1;
        end
      end else if (armed && !gap_cnt[COARSE_W]) begin
        gap_cnt <= gap_cnt + 1'b1;
        if (gap_cnt == GAP_LAST) overflow_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpc_period_meter.sv
`timescale 1ns/1ps
module mpc_period_meter #(
  parameter int unsigned COARSE_W    = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PERIOD_W   = COARSE_W + mpc_pkg::FINE_W
) (
  input  logic                            clk_ref,
  input  logic                            rst,
  input  logic [mpc_pkg::NUM_PHASES-1:0]  phase_clk,
  input  logic                            sig_in,
  output logic [PERIOD_W-1:0]             period_out,
  output logic                            period_valid,
  output logic                            overflow_flag
);
  localparam int unsigned NPH = mpc_pkg::NUM_PHASES;
  localparam int unsigned FW  = mpc_pkg::FINE_W;

  logic [NPH-1:0] sync_word;
  logic           edge_hit;
  logic [FW-1:0]  fine_code;

  mpc_phase_capture #(.NPH(NPH), .SYNC_STAGES(SYNC_STAGES)) capture_i (
    .clk_ref(clk_ref), .rst(rst), .phase_clk(phase_clk),
    .sig_in(sig_in), .word(sync_word)
  );

  mpc_edge_locator #(.NPH(NPH), .FINE_W(FW)) locate_i (
    .clk_ref(clk_ref), .rst(rst), .word(sync_word),
    .edge_hit(edge_hit), .fine_code(fine_code)
  );

  mpc_period_calc #(.COARSE_W(COARSE_W), .FINE_W(FW)) calc_i (
    .clk_ref(clk_ref), .rst(rst), .edge_hit(edge_hit), .fine_code(fine_code),
    .period_out(period_out), .period_valid(period_valid),
    .overflow_flag(overflow_flag)
  );
endmodule

// File: rtl/mpc_period_meter_chk.sv
`timescale 1ns/1ps
module mpc_period_meter_chk #(
  parameter int unsigned NPH      = 16,
  parameter int unsigned FINE_W   = 4,
  parameter int unsigned PERIOD_W = 36
) (
  input logic                clk_ref,
  input logic                rst,
  input logic [NPH-1:0]      word,
  input logic                edge_hit,
  input logic [FINE_W-1:0]   fine_code,
  input logic [PERIOD_W-1:0] period_out,
  input logic                period_valid,
  input logic                overflow_flag
);
  logic seen_edge;
  always_ff @(posedge clk_ref) begin
    if (rst) seen_edge <= 1'b0;
    else if (edge_hit) seen_edge <= 1'b1;
  end

  // R1: reset clears every output
  a_r1_reset_clears: assert property (@(posedge clk_ref)
    rst |=> (!period_valid && !overflow_flag && period_out == '0));

  // R3: the reported code points at a 1 in the word it was decoded from
  a_r3_code_on_one: assert property (@(posedge clk_ref) disable iff (rst)
    edge_hit |-> ((($past(word) >> fine_code) & NPH'(1)) != '0));

  // R5: the first edge after reset gives no strobe
  a_r5_first_silent: assert property (@(posedge clk_ref) disable iff (rst)
    (edge_hit && !seen_edge) |=> !period_valid);

  // R6: a strobe only follows a detected edge
  a_r6_valid_from_hit: assert property (@(posedge clk_ref) disable iff (rst)
    period_valid |-> $past(edge_hit));

  // R6: the result holds between strobes
  a_r6_hold_result: assert property (@(posedge clk_ref) disable iff (rst)
    !period_valid |-> $stable(period_out));

  // R7: overflow is sticky
  a_r7_sticky_overflow: assert property (@(posedge clk_ref) disable iff (rst)
    overflow_flag |=> overflow_flag);
endmodule

bind mpc_period_meter mpc_period_meter_chk #(
  .NPH(mpc_pkg::NUM_PHASES), .FINE_W(mpc_pkg::FINE_W), .PERIOD_W(PERIOD_W)
) chk_i (
  .clk_ref(clk_ref), .rst(rst), .word(sync_word), .edge_hit(edge_hit),
  .fine_code(fine_code), .period_out(period_out),
  .period_valid(period_valid), .overflow_flag(overflow_flag)
);

// File: tb/mpc_period_meter_tb_top.sv
`timescale 1ns/1ps
module mpc_period_meter_tb_top;
  localparam int CW = 8;
  localparam int PW = CW + 4;
  localparam longint MASK = (longint'(1) << PW) - 1;

  logic          clk_ref = 1'b0;
  logic          rst     = 1'b1;
  logic          sig_in  = 1'b0;
  logic [15:0]   phase_clk;
  logic [PW-1:0] period_out;
  logic          period_valid;
  logic          overflow_flag;

  int     cyc = 0;
  int     vectors = 0;
  int     miscompares = 0;
  int     n_valid = 0;
  bit     prev_valid = 1'b0;
  bit     have_prev = 1'b0;
  longint prev_stamp = 0;
  longint exp_q[$];
  string  tag = "R4";
  real    skew9 = 0.0;
  bit     done = 1'b0;

  always #5 clk_ref = ~clk_ref;
  always @(posedge clk_ref) cyc = cyc + 1;

  // Phase k pulses k/16 period after the reference edge (plus a fixed 0.3 ns).
  for (genvar k = 0; k < 16; k++) begin : g_ph
    logic ph = 1'b0;
    always @(posedge clk_ref) begin
      #(0.3 + k * 0.625 - ((k == 9) ? skew9 : 0.0));
      ph = 1'b1;
      #0.2 ph = 1'b0;
    end
    assign phase_clk[k] = ph;
  end

  mpc_period_meter #(.COARSE_W(CW)) dut_i (
    .clk_ref(clk_ref), .rst(rst), .phase_clk(phase_clk), .sig_in(sig_in),
    .period_out(period_out), .period_valid(period_valid),
    .overflow_flag(overflow_flag)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Rising edge placed so that phase n is the first to see it.
  task automatic pulse(input int gap, input int n);
    longint stamp;
    repeat (gap) @(posedge clk_ref);
    #(0.1 + n * 0.625);
    sig_in = 1'b1;
    stamp = longint'(cyc) * 16 + n;
    if (have_prev) exp_q.push_back((stamp - prev_stamp) & MASK);
    prev_stamp = stamp;
    have_prev  = 1'b1;
    @(posedge clk_ref);
    @(posedge clk_ref);
    #1 sig_in = 1'b0;
  endtask

  // Reference model compared every clock.
  always @(negedge clk_ref) begin
    if (!rst) begin
      if (period_valid) begin
        n_valid++;
        chk("R6", longint'(prev_valid), 0);
        if (exp_q.size() == 0) chk("R5", 1, 0);
        else chk(tag, longint'(period_out), exp_q.pop_front());
      end
      prev_valid = period_valid;
    end else begin
      prev_valid = 1'b0;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk_ref);
    @(negedge clk_ref);
    chk("R1", longint'(period_valid), 0);
    chk("R1", longint'(period_out), 0);
    chk("R1", longint'(overflow_flag), 0);
    rst = 1'b0;

    // R5: first edge only arms
    tag = "R5";
    pulse(4, 3);
    repeat (8) @(posedge clk_ref);
    @(negedge clk_ref);
    chk("R5", n_valid, 0);

    // R4: mixed codes and gaps
    tag = "R4";
    pulse(6, 5); pulse(7, 0); pulse(5, 15); pulse(9, 1);
    pulse(4, 15); pulse(4, 0); pulse(12, 8);

    // R2: every phase in turn
    tag = "R2";
    for (int n = 0; n < 16; n++) pulse(5, n);

    // R8: many edges across several coarse wraps
    tag = "R8";
    for (int i = 0; i < 60; i++) pulse(13 + (i % 5), (i * 7) % 16);

    // R3: phase 9 samples two slots early, leaving a bubble above code 8
    repeat (3) @(posedge clk_ref);
    skew9 = 1.25;
    tag = "R3";
    pulse(5, 8); pulse(6, 8); pulse(5, 3); pulse(7, 8); pulse(5, 12);
    repeat (3) @(posedge clk_ref);
    skew9 = 0.0;
    repeat (8) @(posedge clk_ref);
    @(negedge clk_ref);
    chk("R6", exp_q.size(), 0);

    // R7: long gap sets a sticky flag
    tag = "R7";
    chk("R7", longint'(overflow_flag), 0);
    pulse(300, 4);
    repeat (5) @(posedge clk_ref);
    @(negedge clk_ref);
    chk("R7", longint'(overflow_flag), 1);
    pulse(5, 2);
    repeat (6) @(posedge clk_ref);
    @(negedge clk_ref);
    chk("R7", longint'(overflow_flag), 1);

    // R1 / R5 again after a mid-run reset
    @(negedge clk_ref);
    rst = 1'b1;
    exp_q.delete();
    have_prev = 1'b0;
    repeat (2) @(posedge clk_ref);
    @(negedge clk_ref);
    chk("R1", longint'(overflow_flag), 0);
    chk("R1", longint'(period_valid), 0);
    chk("R1", longint'(period_out), 0);
    rst = 1'b0;
    n_valid = 0;
    tag = "R5";
    pulse(4, 6);
    repeat (8) @(posedge clk_ref);
    @(negedge clk_ref);
    chk("R5", n_valid, 0);
    tag = "R6";
    pulse(6, 7); pulse(4, 14);
    repeat (8) @(posedge clk_ref);
    @(negedge clk_ref);
    chk("R6", n_valid, 2);
    chk("R6", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule